// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control sequencer of a small 8-bit processor core. It owns the context registers: the 16-bit program counter, the index register, the accumulator, the condition byte and the stack pointer. Between instructions it has a single decision cycle. If the interrupt mask in the condition byte is clear and the arbiter reports a pending request, the sequencer saves the context on a byte-wide stack. It then masks further interrupts and jumps through the two-byte vector that the arbiter names. In every other case it hands control to the instruction engine for one instruction.

When the instruction engine reports a return-from-interrupt, the sequencer pops the saved context in the opposite order. Restoring the condition byte also restores the mask, which was clear when the context was saved, so interrupts are enabled again without a separate step. Decoding, the ALU and the memory are outside the block. The instruction engine talks to it through a start pulse and a done strobe that carries the new register values. Memory is a byte bus whose read data is valid in the same cycle as the address.

Top module: `irq_ctx_seq`

## Requirements
- R1: While the mask bit (bit 3 of the condition byte) is set, a pending request is not taken. The decision cycle raises `exec_go`, no stack write occurs, and the program counter is not loaded from any vector.
- R2: When the mask is clear and no request is pending, the decision cycle raises `exec_go`. The values presented on `exec_pc`, `exec_a`, `exec_x` and `exec_cc` with `exec_done` (while `exec_iret` is low) become the context.
- R3: Taking an interrupt writes five bytes in five consecutive cycles, with no `exec_go` in between. The bytes are: program-counter low byte at SP, program-counter high byte at SP-1, index at SP-2, accumulator at SP-3, and the pre-entry condition byte at SP-4. SP ends five lower.
- R4: After the writes, the mask bit is set and the other condition bits are kept. The program counter becomes the byte read at the vector address (high byte) joined with the byte at vector address + 1 (low byte). The vector address is sampled in the decision cycle.
- R5: `irq_ack` is a one-cycle pulse, raised exactly once per entry. It comes in the cycle right after the condition-byte write, which is the cycle that reads the high vector byte. The block never clears the pending input itself.
- R6: `exec_done` with `exec_iret` high reads SP+1 to SP+5 into the condition byte, accumulator, index, program-counter high byte and program-counter low byte, in that order. SP ends five higher. The other `exec_*` values given with that strobe are ignored, and the mask afterwards is the restored one.
- R7: During reset, SP is 0x01FF, the condition byte is 0x08, the accumulator and index are zero, and nothing is written. After reset, the program-counter high byte is read from 0xFFFE and the low byte from 0xFFFF. `exec_go` first rises two cycles after `rst_n` goes high.
- R8: If the handler clears the mask, a new request nests: its context is stacked below the first. If a request is pending when a return restores a clear mask, entry follows at once, before any instruction.
- R9: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pend | input | 1 | Arbiter reports an unmasked-source request |
| irq_vec | input | 16 | Address of the high vector byte of the winning source |
| irq_ack | output | 1 | Pulse when the vector is fetched |
| exec_go | output | 1 | Start one instruction |
| exec_done | input | 1 | Instruction finished |
| exec_iret | input | 1 | Finished instruction was a return-from-interrupt |
| exec_pc | input | 16 | New program counter after the instruction |
| exec_a | input | 8 | New accumulator |
| exec_x | input | 8 | New index register |
| exec_cc | input | 8 | New condition byte |
| mem_addr | output | 16 | Byte bus address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| ctx_pc | output | 16 | Current program counter |
| ctx_a | output | 8 | Current accumulator |
| ctx_x | output | 8 | Current index register |
| ctx_cc | output | 8 | Current condition byte |
| ctx_sp | output | 16 | Current stack pointer |

## Verification
The assertions check, on every cycle, the following: the stack pointer moves down by one with each write and up on the first pop; the mask is set during the low-vector fetch; the acknowledge lasts one cycle; no instruction starts while an unmasked request is pending; and reads and writes never coincide. Other behaviour can only be shown by the bench scenarios, which compare against a behavioural model with its own stack queue. These are the byte order and addresses of the stacked context, the vector value that lands in the program counter, the ignored return-strobe payload, nesting, and immediate re-entry after a return.

// File: rtl/isq_pkg.sv
// Shared types for the interrupt entry/return sequencer.
// Assumes: one state per bus cycle; the encoding is local to this block.
package isq_pkg;
    typedef enum logic [3:0] {
        S_RVH,  S_RVL,  S_DEC,  S_EXE,
        S_PPCL, S_PPCH, S_PX,   S_PA,   S_PCC,
        S_VH,   S_VL,
        S_OCC,  S_OA,   S_OX,   S_OPCH, S_OPCL
    } isq_state_e;
endpackage

// File: rtl/isq_fsm.sv
// Control state machine: decides between an instruction and an interrupt
// entry, then steps the push, vector and pop sequences one byte per cycle.
// Assumes: mask comes from the live condition byte; exec_done is only
// looked at while an instruction is in flight.
module isq_fsm
    import isq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mask,
    input  logic       irq_pend,
    input  logic       exec_done,
    input  logic       exec_iret,
    output isq_state_e st,
    output logic       exec_go,
    output logic       irq_ack
);
    isq_state_e st_nx;
    logic       take;

    assign take    = irq_pend && !mask;
    assign exec_go = (st == S_DEC) && !take;
    assign irq_ack = (st == S_VH);

    // State register, reset enters the reset-vector fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_RVH;
        else        st <= st_nx;
    end

    // Next-state selection.
    always_comb begin
        st_nx = st;
        case (st)
            S_RVH:  st_nx = S_RVL;
            S_RVL:  st_nx = S_DEC;
            S_DEC:  st_nx = take ? S_PPCL : S_EXE;
            S_EXE:  if (exec_done) st_nx = exec_iret ? S_OCC : S_DEC;
            S_PPCL: st_nx = S_PPCH;
            S_PPCH: st_nx = S_PX;
            S_PX:   st_nx = S_PA;
            S_PA:   st_nx = S_PCC;
            S_PCC:  st_nx = S_VH;
            S_VH:   st_nx = S_VL;
            S_VL:   st_nx = S_DEC;
            S_OCC:  st_nx = S_OA;
            S_OA:   st_nx = S_OX;
            S_OX:   st_nx = S_OPCH;
            S_OPCH: st_nx = S_OPCL;
            S_OPCL: st_nx = S_DEC;
            default: st_nx = S_RVH;
        endcase
    end

    // R5: the acknowledge never lasts longer than one cycle.
    p_ack_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);
endmodule

// File: rtl/isq_regs.sv
// Context register file: program counter, accumulator, index, condition
// byte, stack pointer and the latched vector address.
// Assumes: AW == 2*DW; memory read data is valid in the cycle of the read.
module isq_regs
    import isq_pkg::*;
#(
    parameter int              DW       = 8,
    parameter int              AW       = 2 * DW,
    parameter logic [AW-1:0]   SP_TOP   = 16'h01FF,
    parameter int              MASK_BIT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  isq_state_e    st,
    input  logic [DW-1:0] mem_rdata,
    input  logic [AW-1:0] irq_vec,
    input  logic          exec_done,
    input  logic          exec_iret,
    input  logic [AW-1:0] exec_pc,
    input  logic [DW-1:0] exec_a,
    input  logic [DW-1:0] exec_x,
    input  logic [DW-1:0] exec_cc,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] a,
    output logic [DW-1:0] x,
    output logic [DW-1:0] cc,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] vec_q
);
    localparam logic [AW-1:0] ONE      = AW'(1);
    localparam logic [DW-1:0] MASK_SET = DW'(1) << MASK_BIT;

    // Register updates per sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= '0;
            a     <= '0;
            x     <= '0;
            cc    <= MASK_SET;
            sp    <= SP_TOP;
            vec_q <= '0;
        end else begin
            if (st == S_DEC) vec_q <= irq_vec;
            case (st)
                S_RVH, S_VH, S_OPCH: pc[AW-1:DW] <= mem_rdata;
                S_RVL, S_VL, S_OPCL: pc[DW-1:0]  <= mem_rdata;
                S_EXE: if (exec_done && !exec_iret) begin
                    pc <= exec_pc;
                    a  <= exec_a;
                    x  <= exec_x;
                    cc <= exec_cc;
                end
                S_PPCL, S_PPCH, S_PX, S_PA, S_PCC: sp <= sp - ONE;
                S_OCC: cc <= mem_rdata;
                S_OA:  a  <= mem_rdata;
                S_OX:  x  <= mem_rdata;
                default: ;
            endcase
            if (st == S_OCC || st == S_OA || st == S_OX || st == S_OPCH || st == S_OPCL)
                sp <= sp + ONE;
            if (st == S_VH) cc[MASK_BIT] <= 1'b1;
        end
    end
endmodule

// File: rtl/isq_bus.sv
// Byte bus driver: address, strobes and write data for each sequencer state.
// Assumes: pushes post-decrement, pops pre-increment; the high vector byte
// sits at the latched vector address and the low byte right above it.
module isq_bus
    import isq_pkg::*;
#(
    parameter int            DW        = 8,
    parameter int            AW        = 2 * DW,
    parameter logic [AW-1:0] RESET_VEC = 16'hFFFE
) (
    input  isq_state_e    st,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] cc,
    input  logic [AW-1:0] sp,
    input  logic [AW-1:0] vec_q,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata
);
    localparam logic [AW-1:0] ONE = AW'(1);

    // Bus cycle decode.
    always_comb begin
        mem_addr  = pc;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        case (st)
            S_RVH: begin mem_addr = RESET_VEC;       mem_rd = 1'b1; end
            S_RVL: begin mem_addr = RESET_VEC + ONE; mem_rd = 1'b1; end
            S_PPCL: begin mem_addr = sp; mem_wr = 1'b1; mem_wdata = pc[DW-1:0];  end
            S_PPCH: begin mem_addr = sp; mem_wr = 1'b1; mem_wdata = pc[AW-1:DW]; end
            S_PX:   begin mem_addr = sp; mem_wr = 1'b1; mem_wdata = x;  end
            S_PA:   begin mem_addr = sp; mem_wr = 1'b1; mem_wdata = a;  end
            S_PCC:  begin mem_addr = sp; mem_wr = 1'b1; mem_wdata = cc; end
            S_VH: begin mem_addr = vec_q;       mem_rd = 1'b1; end
            S_VL: begin mem_addr = vec_q + ONE; mem_rd = 1'b1; end
            S_OCC, S_OA, S_OX, S_OPCH, S_OPCL: begin
                mem_addr = sp + ONE;
                mem_rd   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_ctx_seq.sv
// Top of the interrupt entry/return sequencer: wires the state machine,
// the context registers and the bus driver, and holds the cross-module
// checks.
// Assumes: synchronous active-low reset; the arbiter keeps irq_pend high
// until the source is cleared by its peripheral.
module irq_ctx_seq
    import isq_pkg::*;
#(
    parameter int                DW        = 8,
    parameter logic [2*DW-1:0]   SP_TOP    = 16'h01FF,
    parameter logic [2*DW-1:0]   RESET_VEC = 16'hFFFE,
    parameter int                MASK_BIT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_pend,
    input  logic [2*DW-1:0]   irq_vec,
    output logic              irq_ack,
    output logic              exec_go,
    input  logic              exec_done,
    input  logic              exec_iret,
    input  logic [2*DW-1:0]   exec_pc,
    input  logic [DW-1:0]     exec_a,
    input  logic [DW-1:0]     exec_x,
    input  logic [DW-1:0]     exec_cc,
    output logic [2*DW-1:0]   mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic [2*DW-1:0]   ctx_pc,
    output logic [DW-1:0]     ctx_a,
    output logic [DW-1:0]     ctx_x,
    output logic [DW-1:0]     ctx_cc,
    output logic [2*DW-1:0]   ctx_sp
);
    localparam int            AW  = 2 * DW;
    localparam logic [AW-1:0] ONE = AW'(1);

    isq_state_e    st;
    logic [AW-1:0] vec_q;

    isq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask      (ctx_cc[MASK_BIT]),
        .irq_pend  (irq_pend),
        .exec_done (exec_done),
        .exec_iret (exec_iret),
        .st        (st),
        .exec_go   (exec_go),
        .irq_ack   (irq_ack)
    );

    isq_regs #(.DW(DW), .AW(AW), .SP_TOP(SP_TOP), .MASK_BIT(MASK_BIT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .st        (st),
        .mem_rdata (mem_rdata),
        .irq_vec   (irq_vec),
        .exec_done (exec_done),
        .exec_iret (exec_iret),
        .exec_pc   (exec_pc),
        .exec_a    (exec_a),
        .exec_x    (exec_x),
        .exec_cc   (exec_cc),
        .pc        (ctx_pc),
        .a         (ctx_a),
        .x         (ctx_x),
        .cc        (ctx_cc),
        .sp        (ctx_sp),
        .vec_q     (vec_q)
    );

    isq_bus #(.DW(DW), .AW(AW), .RESET_VEC(RESET_VEC)) u_bus (
        .st        (st),
        .pc        (ctx_pc),
        .a         (ctx_a),
        .x         (ctx_x),
        .cc        (ctx_cc),
        .sp        (ctx_sp),
        .vec_q     (vec_q),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata)
    );

    // R7: first cycle out of reset sees the stack top and a set mask.
    p_reset_ctx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ctx_sp == SP_TOP && ctx_cc[MASK_BIT]));

    // R1: no instruction starts while an unmasked request is pending.
    p_go_respects_pend_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_go && irq_pend) |-> ctx_cc[MASK_BIT]);

    // R3: every stack write moves the stack pointer down by one.
    p_push_sp_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (ctx_sp == $past(ctx_sp) - ONE));

    // R4: the mask is already set while the low vector byte is fetched.
    p_mask_after_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_VL) |-> ctx_cc[MASK_BIT]);

    // R6: the first pop moves the stack pointer up by one.
    p_pop_sp_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_OCC) |=> (ctx_sp == $past(ctx_sp) + ONE));

    // R9: read and write strobes are exclusive.
    p_rw_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));
endmodule

// File: tb/irq_ctx_seq_tb.sv
`timescale 1ns/1ps
module irq_ctx_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq_pend;
    logic [15:0] irq_vec;
    logic        irq_ack;
    logic        exec_go;
    logic        exec_done;
    logic        exec_iret;
    logic [15:0] exec_pc;
    logic [7:0]  exec_a, exec_x, exec_cc;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [15:0] ctx_pc, ctx_sp;
    logic [7:0]  ctx_a, ctx_x, ctx_cc;

    always #2.5 clk = ~clk;

    irq_ctx_seq dut_i (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_vec(irq_vec),
        .irq_ack(irq_ack), .exec_go(exec_go), .exec_done(exec_done),
        .exec_iret(exec_iret), .exec_pc(exec_pc), .exec_a(exec_a),
        .exec_x(exec_x), .exec_cc(exec_cc), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ctx_pc(ctx_pc), .ctx_a(ctx_a),
        .ctx_x(ctx_x), .ctx_cc(ctx_cc), .ctx_sp(ctx_sp)
    );

    // Memory stub: stack page 0x01xx, vector page 0xFFxx.
    logic [7:0] stk  [0:255];
    logic [7:0] vtab [0:255];
    assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] :
                       (mem_addr[15:8] == 8'hFF) ? vtab[mem_addr[7:0]] : 8'h00;
    always @(posedge clk)
        if (mem_wr && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int last_wr_cyc = 0;
    int wr_cnt = 0;
    int acks = 0;
    int exp_acks = 0;
    logic [15:0] exp_vec;

    // Reference model state.
    logic [15:0] m_pc, m_sp;
    logic [7:0]  m_a, m_x, m_cc;
    logic [7:0]  m_stk[$];
    logic [23:0] exp_wr[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] vget(input logic [15:0] ad);
        return (ad[15:8] == 8'hFF) ? vtab[ad[7:0]] : 8'h00;
    endfunction

    // Per-clock monitor: stack writes against the model, ack placement.
    always @(negedge clk) begin : mon
        logic [23:0] e;
        cyc++;
        if (!rst_n) begin
            if (mem_wr) chk(1'b0, "R7", "write during reset", {16'h0, mem_addr}, 0);
        end else begin
            if (mem_wr && mem_rd) chk(1'b0, "R9", "read and write together", 1, 0);
            if (mem_wr) begin
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R3", "unexpected write", {8'h0, mem_addr, mem_wdata}, 0);
                end else begin
                    e = exp_wr.pop_front();
                    chk({mem_addr, mem_wdata} == e, "R3", "stack byte",
                        {8'h0, mem_addr, mem_wdata}, {8'h0, e});
                    if (wr_cnt % 5 != 0)
                        chk(cyc == last_wr_cyc + 1, "R3", "consecutive writes",
                            cyc - last_wr_cyc, 1);
                end
                wr_cnt++;
                last_wr_cyc = cyc;
            end
            if (irq_ack) begin
                acks++;
                chk(cyc == last_wr_cyc + 1, "R5", "ack after CC push", cyc - last_wr_cyc, 1);
                chk(mem_rd && mem_addr == exp_vec, "R4", "high vector read",
                    {15'h0, mem_rd, mem_addr}, {16'h1, exp_vec});
            end
        end
    end

    task automatic model_entry();
        exp_wr.push_back({m_sp,         m_pc[7:0]});
        exp_wr.push_back({m_sp - 16'd1, m_pc[15:8]});
        exp_wr.push_back({m_sp - 16'd2, m_x});
        exp_wr.push_back({m_sp - 16'd3, m_a});
        exp_wr.push_back({m_sp - 16'd4, m_cc});
        m_stk.push_back(m_pc[7:0]);
        m_stk.push_back(m_pc[15:8]);
        m_stk.push_back(m_x);
        m_stk.push_back(m_a);
        m_stk.push_back(m_cc);
        m_sp  = m_sp - 16'd5;
        m_cc  = m_cc | 8'h08;
        m_pc  = {vget(irq_vec), vget(irq_vec + 16'd1)};
        exp_vec = irq_vec;
        exp_acks++;
    endtask

    task automatic model_return();
        m_cc = m_stk.pop_back();
        m_a  = m_stk.pop_back();
        m_x  = m_stk.pop_back();
        m_pc[15:8] = m_stk.pop_back();
        m_pc[7:0]  = m_stk.pop_back();
        m_sp = m_sp + 16'd5;
    endtask

    // One instruction slot: model decision, wait for exec_go, compare the
    // context, then answer as the instruction engine.
    task automatic do_insn(input logic [15:0] npc, input logic [7:0] na,
                           input logic [7:0] nx, input logic [7:0] ncc,
                           input bit iret, input string tag);
        int n;
        #1;
        if (!m_cc[3] && irq_pend) model_entry();
        n = 0;
        while (!exec_go && n < 60) begin
            @(negedge clk);
            n++;
            if (irq_ack) irq_pend = 1'b0;
        end
        chk(exec_go == 1'b1, tag, "exec_go seen", {31'h0, exec_go}, 1);
        chk(ctx_pc == m_pc, tag, "pc", {16'h0, ctx_pc}, {16'h0, m_pc});
        chk(ctx_a == m_a && ctx_x == m_x, tag, "a,x", {16'h0, ctx_a, ctx_x}, {16'h0, m_a, m_x});
        chk(ctx_cc == m_cc, tag, "cc", {24'h0, ctx_cc}, {24'h0, m_cc});
        chk(ctx_sp == m_sp, tag, "sp", {16'h0, ctx_sp}, {16'h0, m_sp});
        chk(exp_wr.size() == 0, "R3", "all pushes done", exp_wr.size(), 0);
        chk(acks == exp_acks, "R5", "ack count", acks, exp_acks);
        exec_pc = npc; exec_a = na; exec_x = nx; exec_cc = ncc;
        exec_iret = iret;
        exec_done = 1'b1;
        @(negedge clk);
        @(negedge clk);
        exec_done = 1'b0;
        exec_iret = 1'b0;
        if (iret) model_return();
        else begin
            m_pc = npc; m_a = na; m_x = nx; m_cc = ncc;
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < 256; i++) begin
            stk[i]  = 8'h00;
            vtab[i] = 8'h00;
        end
        vtab[8'hFE] = 8'h80; vtab[8'hFF] = 8'h00;
        vtab[8'hF6] = 8'h9A; vtab[8'hF7] = 8'h55;
        vtab[8'hE0] = 8'h12; vtab[8'hE1] = 8'h34;
        rst_n = 1'b0; irq_pend = 1'b0; irq_vec = 16'hFFF6;
        exec_done = 1'b0; exec_iret = 1'b0;
        exec_pc = 16'h0; exec_a = 8'h0; exec_x = 8'h0; exec_cc = 8'h0;
        repeat (3) @(negedge clk);
        // R7: state held in reset.
        chk(ctx_sp == 16'h01FF && ctx_cc == 8'h08, "R7", "reset sp,cc",
            {ctx_sp, 8'h0, ctx_cc}, {16'h01FF, 16'h0008});
        chk(ctx_a == 8'h00 && ctx_x == 8'h00 && exec_go == 1'b0, "R7", "reset a,x,go",
            {15'h0, exec_go, ctx_a, ctx_x}, 0);
        rst_n = 1'b1;
        m_pc = 16'h8000; m_cc = 8'h08; m_sp = 16'h01FF; m_a = 8'h00; m_x = 8'h00;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!exec_go && n < 10);
        chk(n == 2, "R7", "first exec_go latency", n, 2);

        do_insn(16'h8001, 8'h11, 8'h22, 8'h08, 1'b0, "R7");
        irq_pend = 1'b1; irq_vec = 16'hFFF6;
        do_insn(16'h8002, 8'h11, 8'h22, 8'h00, 1'b0, "R1");   // masked: no entry
        do_insn(16'h9A56, 8'h33, 8'h44, 8'h09, 1'b0, "R4");   // entry to 0x9A55
        do_insn(16'hDEAD, 8'hEE, 8'hEE, 8'hFF, 1'b1, "R2");   // return, payload ignored
        do_insn(16'h8003, 8'h55, 8'h66, 8'h00, 1'b0, "R6");   // context restored
        chk(irq_pend == 1'b0, "R2", "no pending after clear", {31'h0, irq_pend}, 0);
        irq_pend = 1'b1; irq_vec = 16'hFFE0;
        do_insn(16'h1235, 8'h77, 8'h88, 8'h00, 1'b0, "R4");   // entry to 0x1234, unmask
        irq_pend = 1'b1; irq_vec = 16'hFFF6;
        do_insn(16'hBEEF, 8'h01, 8'h02, 8'h03, 1'b1, "R8");   // nested entry, return
        irq_pend = 1'b1; irq_vec = 16'hFFE0;
        do_insn(16'hCAFE, 8'h04, 8'h05, 8'h06, 1'b1, "R8");   // back-to-back re-entry
        do_insn(16'hF00D, 8'h07, 8'h08, 8'h09, 1'b1, "R6");   // inner context back
        do_insn(16'h8004, 8'h00, 8'h00, 8'h08, 1'b0, "R6");   // outer context back
        repeat (3) @(negedge clk);
        chk(exp_wr.size() == 0 && acks == 4, "R5", "final ack total", acks, 4);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule